// File: doc/BRIEF.md
# Supervisory Reset Controller with Watchdog

This block generates the reset for a processor from three sources: a digital undervoltage flag from an external supply comparator, an active-low manual reset input (typically a push-button), and a watchdog that the processor must keep servicing. The controller asserts reset whenever any source is active. After the last source clears, it keeps reset asserted for a fixed number of clock cycles. It drives an active-low and an active-high copy of the same reset state.

The watchdog restarts on every rising or falling edge of its strobe input. It is held at zero for as long as reset is asserted. A separate flag marks the strobe as undriven, and while that flag is set the watchdog never causes a reset. The manual reset input is synchronized and filtered, so short low glitches are rejected. All timeouts are parameters counted in clock cycles. By default they are derived from the clock frequency: a 200 ms reset stretch, a 1.6 s watchdog and a 1 µs minimum manual pulse.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst_o` is 1. After `rst_n` rises, `sys_rst_o` stays 1 for exactly `HOLD_CYC` cycles and then falls.
- R2: With `uv_flag_i` high, `sys_rst_o` is 1 from the next cycle on. It falls exactly `HOLD_CYC` cycles after `uv_flag_i` falls. A new cause that appears during this stretch restarts the full `HOLD_CYC` count.
- R3: A low pulse on `mrst_n_i` that lasts fewer than `FILT_CYC` clock cycles has no effect on `sys_rst_o`.
- R4: A low pulse on `mrst_n_i` of `FILT_CYC` cycles or longer drives `sys_rst_o` to 1 exactly `FILT_CYC`+3 cycles after the pulse starts. After `mrst_n_i` returns high, `sys_rst_o` falls exactly `HOLD_CYC`+3 cycles later. The extra cycles come from the two-flop synchronizer and the filter.
- R5: With the watchdog enabled and the strobe held at a constant level, `sys_rst_o` rises exactly `WDT_CYC` cycles after it last fell. That pulse lasts exactly `HOLD_CYC` cycles. The watchdog then starts a fresh count of `WDT_CYC` cycles.
- R6: Both a rising and a falling edge of `wd_strobe_i` restart the watchdog. This includes a strobe pulse only one clock cycle wide. A strobe that changes level more often than every `WDT_CYC` cycles never causes a reset.
- R7: While reset is asserted, the watchdog counter is held at zero. However long reset lasts, the count starts only when reset deasserts.
- R8: While `wd_float_i` is 1, the watchdog never asserts reset. When `wd_float_i` returns to 0, the watchdog starts counting from zero.
- R9: `sys_rst_n_o` is always the inverse of `sys_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| uv_flag_i | input | 1 | Undervoltage flag, 1 while the supply is below threshold (synchronous) |
| mrst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| wd_strobe_i | input | 1 | Watchdog strobe, either edge services the watchdog, asynchronous |
| wd_float_i | input | 1 | 1 marks the strobe as undriven and disables the watchdog (static) |
| sys_rst_n_o | output | 1 | Reset output, active low |
| sys_rst_o | output | 1 | Reset output, active high |

## Verification
The bench builds the block with `HOLD_CYC`=20, `WDT_CYC`=40 and `FILT_CYC`=4, so each timeout elapses within tens of cycles. With these values the bench can measure every stretch, latency and expiry to the exact cycle, rather than only checking that it eventually happens. The short filter makes it possible to probe both sides of the glitch boundary: a pulse of `FILT_CYC`-1 cycles and a pulse of exactly `FILT_CYC` cycles. The watchdog window is twice the reset stretch. This lets the bench hold the undervoltage flag for longer than a watchdog period and confirm that the count restarts from zero after release.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  // depth of the input synchronizer chain
  localparam int unsigned SYNC_STAGES = 2;

  // width of a counter that must hold values 0..limit
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync
  import rsup_pkg::*;
#(
  parameter int unsigned          WIDTH   = 1,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [SYNC_STAGES-1:0][WIDTH-1:0] stage_q;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[SYNC_STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {SYNC_STAGES{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign sync_o = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/rsup_mr_filter.sv
module rsup_mr_filter
  import rsup_pkg::*;
#(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_low_i,
  output logic act_o
);
  localparam int unsigned CW = cnt_bits(FILT_CYC);
  localparam logic [CW-1:0] FILT_TOP = CW'(FILT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!mr_low_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != FILT_TOP) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign act_o = (cnt_q == FILT_TOP);

  AST_MR_ACT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> $past(mr_low_i)); // R3
endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog
  import rsup_pkg::*;
#(
  parameter int unsigned WDT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic float_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam int unsigned CW = cnt_bits(WDT_CYC);
  localparam logic [CW-1:0] WDT_LAST = CW'(WDT_CYC - 1);

  logic          prev_q;
  logic          strobe_edge;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe_i;
  end

  assign strobe_edge = strobe_i ^ prev_q;

  always_comb begin
    expire_o = (cnt_q == WDT_LAST) & ~hold_i & ~float_i & ~strobe_edge;
    cnt_en   = 1'b1;
    if (hold_i || float_i || strobe_edge || expire_o) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_WD_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0)); // R7
  AST_WD_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_edge |=> (cnt_q == '0)); // R6
  AST_WD_FLOAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    float_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsup_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 1_000_000,
  parameter int unsigned HOLD_CYC = CLK_HZ / 5,
  parameter int unsigned WDT_CYC  = (CLK_HZ / 5) * 8,
  parameter int unsigned FILT_CYC = (CLK_HZ < 1_000_000) ? 1 : CLK_HZ / 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_flag_i,
  input  logic mrst_n_i,
  input  logic wd_strobe_i,
  input  logic wd_float_i,
  output logic sys_rst_n_o,
  output logic sys_rst_o
);
  localparam int unsigned HCW = cnt_bits(HOLD_CYC);
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);

  logic [1:0]     sync_vec;
  logic           mr_act;
  logic           wd_expire;
  logic           cause_any;
  logic           rst_q, rst_d;
  logic [HCW-1:0] hold_cnt_q, hold_cnt_d;
  logic           hold_en;

  // bit 1: manual reset (idle high), bit 0: watchdog strobe
  rsup_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({mrst_n_i, wd_strobe_i}),
    .sync_o  (sync_vec)
  );

  rsup_mr_filter #(.FILT_CYC(FILT_CYC)) u_mr_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_low_i (~sync_vec[1]),
    .act_o    (mr_act)
  );

  rsup_watchdog #(.WDT_CYC(WDT_CYC)) u_watchdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (sync_vec[0]),
    .float_i  (wd_float_i),
    .hold_i   (rst_q),
    .expire_o (wd_expire)
  );

  assign cause_any = uv_flag_i | mr_act | wd_expire;

  always_comb begin
    rst_d      = rst_q;
    hold_cnt_d = hold_cnt_q;
    hold_en    = 1'b0;
    if (cause_any) begin
      rst_d      = 1'b1;
      hold_cnt_d = '0;
      hold_en    = 1'b1;
    end else if (rst_q) begin
      hold_en = 1'b1;
      if (hold_cnt_q == HOLD_LAST) begin
        rst_d      = 1'b0;
        hold_cnt_d = '0;
      end else begin
        hold_cnt_d = hold_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q      <= 1'b1;
      hold_cnt_q <= '0;
    end else if (hold_en) begin
      rst_q      <= rst_d;
      hold_cnt_q <= hold_cnt_d;
    end
  end

  assign sys_rst_o   = rst_q;
  assign sys_rst_n_o = ~rst_q;

  AST_RELEASE_AFTER_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> ($past(hold_cnt_q) == HOLD_LAST)); // R1
  AST_CAUSE_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    cause_any |=> rst_q); // R2
endmodule

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
  localparam int HOLD = 20;
  localparam int WDT  = 40;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 1'b0;
  logic mrst_n = 1'b1;
  logic strobe = 1'b0;
  logic wfloat = 1'b1;
  logic sys_rst_n_o, sys_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rst_supervisor #(.CLK_HZ(1000), .HOLD_CYC(HOLD), .WDT_CYC(WDT), .FILT_CYC(FILT)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_flag_i   (uv),
    .mrst_n_i    (mrst_n),
    .wd_strobe_i (strobe),
    .wd_float_i  (wfloat),
    .sys_rst_n_o (sys_rst_n_o),
    .sys_rst_o   (sys_rst_o)
  );

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pair(input string req);
    check_int(req, int'(sys_rst_n_o ^ sys_rst_o), 1);
  endtask

  task automatic cycles_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sys_rst_o !== lvl && n < 1000);
  endtask

  task automatic steady(input int cyc, input logic lvl, input string req);
    int bad = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (sys_rst_o !== lvl) bad++;
    end
    check_int(req, bad, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic t_powerup();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_int("R1 output asserted in reset", int'(sys_rst_o), 1);
    chk_pair("R9 complement in reset");
    rst_n = 1'b1;
    cycles_until(1'b0, n);
    check_int("R1 power-up stretch", n, HOLD);
    chk_pair("R9 complement after release");
  endtask

  task automatic t_undervoltage();
    int n;
    uv = 1'b1;
    @(negedge clk);
    check_int("R2 assert latency", int'(sys_rst_o), 1);
    chk_pair("R9 complement under uv");
    steady(10, 1'b1, "R2 held while uv high");
    uv = 1'b0;
    cycles_until(1'b0, n);
    check_int("R2 stretch after uv", n, HOLD);
  endtask

  task automatic t_uv_restart();
    int n;
    uv = 1'b1;
    @(negedge clk);
    uv = 1'b0;
    repeat (10) @(negedge clk);
    check_int("R2 still stretching", int'(sys_rst_o), 1);
    uv = 1'b1;
    @(negedge clk);
    uv = 1'b0;
    cycles_until(1'b0, n);
    check_int("R2 restart of stretch", n, HOLD);
  endtask

  task automatic t_mr_glitch();
    mrst_n = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    mrst_n = 1'b1;
    steady(3 * FILT + HOLD, 1'b0, "R3 short low pulse ignored");
  endtask

  task automatic t_mr_boundary();
    int n;
    mrst_n = 1'b0;
    repeat (FILT) @(negedge clk);
    mrst_n = 1'b1;
    cycles_until(1'b1, n);
    check_int("R4 minimum pulse latency", FILT + n, FILT + 3);
    cycles_until(1'b0, n);
  endtask

  task automatic t_mr_long();
    int n;
    mrst_n = 1'b0;
    cycles_until(1'b1, n);
    check_int("R4 manual assert latency", n, FILT + 3);
    steady(10, 1'b1, "R4 held while button low");
    mrst_n = 1'b1;
    cycles_until(1'b0, n);
    check_int("R4 manual release stretch", n, HOLD + 3);
  endtask

  task automatic t_wd_expiry();
    int n;
    wfloat = 1'b0;
    uv = 1'b1;
    steady(3 * WDT, 1'b1, "R7 reset held longer than watchdog");
    uv = 1'b0;
    cycles_until(1'b0, n);
    check_int("R2 stretch before watchdog run", n, HOLD);
    cycles_until(1'b1, n);
    check_int("R7 count starts at release", n, WDT);
    cycles_until(1'b0, n);
    check_int("R5 expiry pulse width", n, HOLD);
    cycles_until(1'b1, n);
    check_int("R5 fresh count after expiry", n, WDT);
    chk_pair("R9 complement on watchdog reset");
  endtask

  task automatic t_wd_service();
    int n;
    int bad = 0;
    cycles_until(1'b0, n);
    check_int("R5 second pulse width", n, HOLD);
    for (int i = 0; i < 12; i++) begin
      repeat (20) begin
        @(negedge clk);
        if (sys_rst_o !== 1'b0) bad++;
      end
      strobe = ~strobe;
    end
    check_int("R6 level toggles service watchdog", bad, 0);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      strobe = ~strobe;
      @(negedge clk);
      strobe = ~strobe;
      repeat (29) begin
        @(negedge clk);
        if (sys_rst_o !== 1'b0) bad++;
      end
    end
    check_int("R6 one-cycle pulses service watchdog", bad, 0);
  endtask

  task automatic t_float();
    int n;
    wfloat = 1'b1;
    steady(3 * WDT, 1'b0, "R8 floating strobe never resets");
    wfloat = 1'b0;
    cycles_until(1'b1, n);
    check_int("R8 fresh count after reconnect", n, WDT);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    t_powerup();
    t_undervoltage();
    t_uv_restart();
    t_mr_glitch();
    t_mr_boundary();
    t_mr_long();
    t_wd_expiry();
    t_wd_service();
    t_float();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule